// File: doc/BRIEF.md
# Banked Interrupt Source Register File

This block collects interrupt sources into four 8-bit banks and presents them to software through a byte-wide register port. The four banks are a low-priority bank, a high-priority bank, a DMA-request bank and a fast-interrupt bank. Each bank has three byte registers:
- a raw status register;
- a request register, which reads as status AND mask and takes a clear action when written;
- an enable mask, which software can read back.

The low-priority bank records rising edges of its inputs as sticky events. Software removes those events by writing ones to the bank's request offset. The other three banks follow their input levels and have no clear action.

Two outputs leave the block. The normal interrupt line is raised by any enabled request in the low, high or DMA bank. The fast-interrupt line is raised by any enabled request in the fast bank. Vector selection and CPU-side handling belong to the software that reads these registers.

Top module: `irqbank_regfile`

## Requirements
- R1: After a synchronous reset, all masks and all latched events are 0, and both `irq_o` and `fiq_o` are low.
- R2: Address map (6-bit byte address). The bank base is 0x00 for low, 0x10 for high, 0x20 for DMA and 0x30 for fast. Within a bank, offset 0x0 is status, 0x4 is request and 0x8 is mask. A write to the mask offset stores the byte, and a later read returns it, so read-modify-write of single bits works. A mask bit of 1 enables the source.
- R3: A read of the request offset returns status AND mask. A source whose mask bit is 0 does not raise any output.
- R4: A low-bank status bit is set on the clock edge that sees its input high when it was low on the previous edge. The bit stays set after the input falls.
- R5: A write to low-bank offset 0x4 clears the status bits where the written byte has 1s, and leaves the other bits unchanged.
- R6: When a clear write and a new rising edge hit the same low-bank bit on the same edge, the bit stays set.
- R7: High, DMA and fast status bits equal the input level sampled at the previous clock edge. A write to their offset 0x4 has no effect.
- R8: DMA bank bits 7:6 carry no source. They read as 0 in status, request and mask, and they never raise an output.
- R9: `irq_o` is the OR of the request bits of the low, high and DMA banks. `fiq_o` is the OR of the fast bank's request bits only.
- R10: Reads of an unmapped address return 0, and writes to an unmapped address change no state. Unmapped addresses are offset 0xC of each bank and any address with bits 1:0 not equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_low_i | input | 8 | Low-priority sources (edge-latched) |
| src_high_i | input | 8 | High-priority sources (level) |
| src_dma_i | input | 8 | DMA request sources (level, bits 5:0 used) |
| src_fast_i | input | 8 | Fast-interrupt sources (level) |
| reg_addr_i | input | 6 | Register byte address |
| reg_wr_i | input | 1 | Write strobe for the current address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Source inputs and register writes take effect at the first rising edge after they are applied. Status, request, mask and the two outputs therefore show the new state one cycle later. Read data has no register on its path, so it follows the address within the same cycle. The bench drives all inputs just after a rising edge and compares against its reference model at the falling edge. Each directed read is sampled one edge after the stimulus that should change it, including the cycle in which a clear and a new edge meet.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    localparam int BYTE_W   = 8;
    localparam int NBANK    = 4;
    localparam int BANK_LSB = 4;
    localparam int BANK_W   = $clog2(NBANK);
    localparam int ADDR_W   = BANK_LSB + BANK_W;

    typedef enum logic [BANK_W-1:0] {
        BK_LOW  = 2'd0,
        BK_HIGH = 2'd1,
        BK_DMA  = 2'd2,
        BK_FAST = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_REQ  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef struct packed {
        logic  hit;
        bank_e bank;
        sel_e  sel;
    } dec_t;

    typedef struct packed {
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] mask;
    } view_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.bank = bank_e'(a[ADDR_W-1:BANK_LSB]);
        d.sel  = sel_e'(a[3:2]);
        d.hit  = (a[1:0] == 2'b00) && (d.sel != SEL_NONE);
        return d;
    endfunction

    function automatic logic [BYTE_W-1:0] valid_bits(input int b);
        return (b == int'(BK_DMA)) ? 8'h3F : 8'hFF;
    endfunction

    function automatic bit is_latched(input int b);
        return b == int'(BK_LOW);
    endfunction

    function automatic bit to_fast(input int b);
        return b == int'(BK_FAST);
    endfunction

endpackage

// File: rtl/irqbank_bank.sv
module irqbank_bank
    import irqbank_pkg::*;
#(
    parameter bit                LATCHED = 1'b0,
    parameter logic [BYTE_W-1:0] VALID   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] src_i,
    input  logic              clr_we_i,
    input  logic [BYTE_W-1:0] clr_data_i,
    input  logic              mask_we_i,
    input  logic [BYTE_W-1:0] mask_data_i,
    output view_t             view_o,
    output logic [BYTE_W-1:0] req_o
);

    logic [BYTE_W-1:0] status_q;
    logic [BYTE_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= mask_data_i & VALID;
        end
    end

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !mask_we_i |=> $stable(mask_q));

    generate
        if (LATCHED) begin : g_edge
            logic [BYTE_W-1:0] prev_q;
            logic [BYTE_W-1:0] rise;

            assign rise = src_i & ~prev_q & VALID;

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q   <= '0;
                    status_q <= '0;
                end else begin
                    prev_q <= src_i;
                    if (clr_we_i) begin
                        status_q <= (status_q & ~clr_data_i) | rise;
                    end else begin
                        status_q <= status_q | rise;
                    end
                end
            end

            assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
                !clr_we_i |=> ((status_q & $past(status_q)) == $past(status_q)));

            assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
                clr_we_i |=> ((status_q & $past(clr_data_i) & ~$past(rise)) == '0));

            assert_edge_wins_R6: assert property (@(posedge clk) disable iff (rst)
                clr_we_i |=> (($past(rise) & ~status_q) == '0));
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst) begin
                    status_q <= '0;
                end else begin
                    status_q <= src_i & VALID;
                end
            end

            assert_level_R7: assert property (@(posedge clk) disable iff (rst)
                $stable(src_i) && !$rose(rst) |=> $stable(status_q));
        end
    endgenerate

    assign view_o.status = status_q;
    assign view_o.mask   = mask_q;
    assign req_o         = status_q & mask_q;

endmodule

// File: rtl/irqbank_regport.sv
module irqbank_regport
    import irqbank_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         wr_i,
    input  view_t [NBANK-1:0]            views_i,
    output logic [NBANK-1:0]             clr_we_o,
    output logic [NBANK-1:0]             mask_we_o,
    output logic [BYTE_W-1:0]            rdata_o
);

    dec_t  dec;
    view_t sel_view;

    assign dec      = decode(addr_i);
    assign sel_view = views_i[dec.bank];

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            clr_we_o[b]  = wr_i && dec.hit && (dec.bank == bank_e'(b[BANK_W-1:0]))
                           && (dec.sel == SEL_REQ);
            mask_we_o[b] = wr_i && dec.hit && (dec.bank == bank_e'(b[BANK_W-1:0]))
                           && (dec.sel == SEL_MASK);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_STAT: rdata_o = sel_view.status;
                SEL_REQ:  rdata_o = sel_view.status & sel_view.mask;
                SEL_MASK: rdata_o = sel_view.mask;
                default:  rdata_o = '0;
            endcase
        end
    end

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |-> (rdata_o == '0));

    assert_dma_top_bits_R8: assert property (@(posedge clk) disable iff (rst)
        (dec.bank == BK_DMA) |-> (rdata_o[7:6] == 2'b00));

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clr_we_o, mask_we_o}));

endmodule

// File: rtl/irqbank_combine.sv
module irqbank_combine
    import irqbank_pkg::*;
(
    input  logic [NBANK-1:0][BYTE_W-1:0] req_i,
    output logic                         irq_o,
    output logic                         fiq_o
);

    logic [NBANK-1:0] any_req;
    logic [NBANK-1:0] fast_sel;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_route
            assign any_req[b]  = |req_i[b];
            assign fast_sel[b] = to_fast(b);
        end
    endgenerate

    assign irq_o = |(any_req & ~fast_sel);
    assign fiq_o = |(any_req & fast_sel);

endmodule

// File: rtl/irqbank_regfile.sv
module irqbank_regfile
    import irqbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        src_low_i,
    input  logic [7:0]        src_high_i,
    input  logic [7:0]        src_dma_i,
    input  logic [7:0]        src_fast_i,
    input  logic [5:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [NBANK-1:0][BYTE_W-1:0] src_all;
    logic [NBANK-1:0][BYTE_W-1:0] req_all;
    view_t [NBANK-1:0]            views;
    logic [NBANK-1:0]             clr_we;
    logic [NBANK-1:0]             mask_we;

    assign src_all[BK_LOW]  = src_low_i;
    assign src_all[BK_HIGH] = src_high_i;
    assign src_all[BK_DMA]  = src_dma_i;
    assign src_all[BK_FAST] = src_fast_i;

    irqbank_regport u_port (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .views_i   (views),
        .clr_we_o  (clr_we),
        .mask_we_o (mask_we),
        .rdata_o   (reg_rdata_o)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            irqbank_bank #(
                .LATCHED (is_latched(b)),
                .VALID   (valid_bits(b))
            ) u_bank (
                .clk         (clk),
                .rst         (rst),
                .src_i       (src_all[b]),
                .clr_we_i    (clr_we[b]),
                .clr_data_i  (reg_wdata_i),
                .mask_we_i   (mask_we[b]),
                .mask_data_i (reg_wdata_i),
                .view_o      (views[b]),
                .req_o       (req_all[b])
            );
        end
    endgenerate

    irqbank_combine u_comb (
        .req_i (req_all),
        .irq_o (irq_o),
        .fiq_o (fiq_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && !fiq_o));

    assert_fast_isolated_R9: assert property (@(posedge clk) disable iff (rst)
        (views[BK_FAST].mask == '0) |-> !fiq_o);

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (views[BK_LOW].mask == '0 && views[BK_HIGH].mask == '0 &&
         views[BK_DMA].mask == '0) |-> !irq_o);

endmodule

// File: tb/irqbank_regfile_tb.sv
module irqbank_regfile_tb;

    localparam int PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src_low = '0, src_high = '0, src_dma = '0, src_fast = '0;
    logic [5:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, fiq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_stat [4];
    logic [7:0] m_mask [4];
    logic [7:0] m_prev;

    always #(PERIOD/2) clk = ~clk;

    irqbank_regfile u_dut (
        .clk(clk), .rst(rst),
        .src_low_i(src_low), .src_high_i(src_high),
        .src_dma_i(src_dma), .src_fast_i(src_fast),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [7:0] vmask(input int b);
        return (b == 2) ? 8'h3F : 8'hFF;
    endfunction

    // Reference model, updated behaviourally on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 4; b++) begin
                m_stat[b] = '0;
                m_mask[b] = '0;
            end
            m_prev = '0;
        end else begin
            automatic logic [7:0] rise = src_low & ~m_prev;
            automatic int bank = int'(addr[5:4]);
            automatic int ofs  = int'(addr[3:0]);
            m_prev = src_low;
            if (wr && bank == 0 && ofs == 4) m_stat[0] = (m_stat[0] & ~wdata) | rise;
            else                             m_stat[0] = m_stat[0] | rise;
            m_stat[1] = src_high;
            m_stat[2] = src_dma & 8'h3F;
            m_stat[3] = src_fast;
            if (wr && ofs == 8) m_mask[bank] = wdata & vmask(bank);
        end
    end

    function automatic logic [7:0] model_read(input logic [5:0] a);
        automatic int bank = int'(a[5:4]);
        case (a[3:0])
            4'h0:    return m_stat[bank];
            4'h4:    return m_stat[bank] & m_mask[bank];
            4'h8:    return m_mask[bank];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model (R3 request reads, R9 outputs)
    always @(negedge clk) begin
        if (!rst && !done) begin
            automatic logic model_irq = |((m_stat[0] & m_mask[0]) | (m_stat[1] & m_mask[1]) |
                                         (m_stat[2] & m_mask[2]));
            automatic logic model_fiq = |(m_stat[3] & m_mask[3]);
            check("R3 model rdata", rdata, model_read(addr));
            check("R9 model irq", {7'b0, irq}, {7'b0, model_irq});
            check("R9 model fiq", {7'b0, fiq}, {7'b0, model_fiq});
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc(1);
        wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [7:0] exp);
        addr = a;
        @(negedge clk);
        check(req, rdata, exp);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(PERIOD * WATCHDOG_CYCLES);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        rd_check("R1 low mask", 6'h08, 8'h00);
        rd_check("R1 fast mask", 6'h38, 8'h00);
        rd_check("R1 low status", 6'h00, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 fiq", {7'b0, fiq}, 8'h00);
        // R2 mask readback and read-modify-write
        wr_reg(6'h18, 8'hA5);
        rd_check("R2 high mask", 6'h18, 8'hA5);
        wr_reg(6'h18, rdata | 8'h02);
        rd_check("R2 high mask rmw", 6'h18, 8'hA7);
        // R8 DMA unused bits
        wr_reg(6'h28, 8'hFF);
        rd_check("R8 dma mask", 6'h28, 8'h3F);
        // R4 edge latch
        src_low = 8'h05;
        cyc(1);
        src_low = 8'h00;
        cyc(1);
        rd_check("R4 low status sticky", 6'h00, 8'h05);
        rd_check("R3 low req masked", 6'h04, 8'h00);
        check("R3 irq masked", {7'b0, irq}, 8'h00);
        wr_reg(6'h08, 8'h04);
        rd_check("R3 low req", 6'h04, 8'h04);
        check("R9 irq from low", {7'b0, irq}, 8'h01);
        // R5 clear
        wr_reg(6'h04, 8'h04);
        rd_check("R5 low status after clear", 6'h00, 8'h01);
        check("R5 irq after clear", {7'b0, irq}, 8'h00);
        // R6 clear and new edge together
        src_low = 8'h02;
        wr_reg(6'h04, 8'h03);
        rd_check("R6 edge wins", 6'h00, 8'h02);
        src_low = 8'h00;
        // R7 level banks
        src_high = 8'h81;
        cyc(1);
        rd_check("R7 high status", 6'h10, 8'h81);
        rd_check("R3 high req", 6'h14, 8'h81);
        wr_reg(6'h14, 8'hFF);
        rd_check("R7 high write ignored", 6'h10, 8'h81);
        src_high = 8'h00;
        cyc(1);
        rd_check("R7 high follows", 6'h10, 8'h00);
        // R8 dma status
        src_dma = 8'hFF;
        cyc(1);
        rd_check("R8 dma status", 6'h20, 8'h3F);
        src_dma = 8'hC0;
        cyc(1);
        rd_check("R8 dma req top bits", 6'h24, 8'h00);
        wr_reg(6'h04, 8'hFF);
        check("R8 no irq from top bits", {7'b0, irq}, 8'h00);
        src_dma = 8'h00;
        // R9 fast path
        wr_reg(6'h38, 8'h10);
        src_fast = 8'h10;
        cyc(1);
        rd_check("R9 fast req", 6'h34, 8'h10);
        check("R9 fiq", {7'b0, fiq}, 8'h01);
        check("R9 irq not from fast", {7'b0, irq}, 8'h00);
        src_fast = 8'h00;
        // R10 unmapped
        rd_check("R10 unmapped 0C", 6'h0C, 8'h00);
        rd_check("R10 unmapped 01", 6'h01, 8'h00);
        wr_reg(6'h3C, 8'hFF);
        wr_reg(6'h09, 8'hFF);
        rd_check("R10 low mask unchanged", 6'h08, 8'h04);
        rd_check("R10 fast mask unchanged", 6'h38, 8'h10);
        cyc(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule